// File: doc/BRIEF.md
# Banked GPIO Port Controller

A general-purpose I/O bank of 32 pins, split into four 8-pin ports, controlled through a simple single-cycle register bus. Each port has its own set of registers: pin configure, output enable, output value, sampled input, interrupt status, interrupt enable, interrupt sense and interrupt clear. A pin drives its pad only when it is both configured and output-enabled.

Inputs pass through a two-flop synchronizer. The synchronized value feeds the input register and the per-pin event detectors. Each pin can be set to detect a rising edge, a falling edge, both edges, a high level or a low level. Status bits that are also enabled are ORed into a single bank interrupt line.

A masked alias window, selected by address bit 11, lets software change chosen pins without a read-modify-write. In a write to this window, the upper data byte selects the pins to change and the lower byte gives their new values.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads zero, `pins_oe_o` and `pins_o` are zero and `irq_o` is low.
- R2: Register words sit at byte offset `sel*0x10 + port*4` with sel 0 configure, 1 output enable, 2 output value, 3 input, 4 status, 5 enable, 6 sense, 7 clear. Address bits 1:0 are ignored, and bits 10:7 must be zero. A plain write replaces bits 7:0, or bits 23:0 for the sense register. Reading at address bit 11 set returns the same value as the plain register.
- R3: A write with address bit 11 set, to configure, output enable, output value, status or enable, changes only the pins whose bit in data 15:8 is 1, loading them from data 7:0. For the sense register, such a write changes only the polarity field (bits 7:0). Pins that are not selected keep their state.
- R4: `pins_oe_o[i]` is configure[i] AND output-enable[i]. `pins_o[i]` is the output-value bit.
- R5: The input register returns the pin levels after a two-flop synchronizer. Writes to it are ignored.
- R6: Sense bit p is the polarity (1 = high or rising). Bit p+8 selects edge mode. Bit p+16 selects both edges while in edge mode. Codes: rising 0x101, falling 0x100, both 0x10100, level high 0x001, level low 0x000, each shifted left by p.
- R7: In level mode the status bit is set on every cycle the active level is seen, so a clear has effect only after the pin leaves that level.
- R8: Writing 1 to a clear-register bit clears that status bit. Writing 0 has no effect. The clear register reads as zero.
- R9: `irq_o` is the OR over all ports of status AND enable.
- R10: Read data appears on `rdata_o` the cycle after `re_i`, and is zero in a cycle that follows no read. Unmapped offsets, the clear register, and the input or clear register in the alias window read zero. Writes to them are ignored.
- R11: A pin edge sets its status bit on the third rising clock edge after the pin changes: two edges for the synchronizer, one for detection.
- R12: When an event and a clear of the same status bit fall in the same cycle, the event wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 12 | Register byte address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, one cycle after `re_i` |
| pins_i | input | 32 | Pin input levels (asynchronous) |
| pins_o | output | 32 | Pin output values |
| pins_oe_o | output | 32 | Pin output enables |
| irq_o | output | 1 | Bank interrupt |

## Verification
Four rules are checked on every cycle:
- A detected event always leaves its status bit set on the next cycle.
- A clear with no event at the same time leaves its bits cleared.
- A masked output write never disturbs unselected pins.
- The read data is zero after a cycle with no read.

Some behaviour can only be shown through the bench's scenarios:
- The exact three-edge latency from a pin change to status.
- The sense-code decoding across all five modes.
- Level re-assertion defeating a clear.
- The event winning over a clear in the same cycle.
- The address decode, including the alias and unmapped holes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [2:0] {
    REG_CNF = 3'd0,
    REG_OE  = 3'd1,
    REG_OUT = 3'd2,
    REG_IN  = 3'd3,
    REG_STA = 3'd4,
    REG_ENB = 3'd5,
    REG_SNS = 3'd6,
    REG_CLR = 3'd7
  } reg_sel_e;

  localparam int unsigned ALIAS_BIT = 11;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                masked_i,
  input  reg_sel_e            sel_i,
  input  logic [3*PORT_W-1:0] wdata_i,
  input  logic [PORT_W-1:0]   pin_i,
  output logic [DATA_W-1:0]   rd_o,
  output logic [PORT_W-1:0]   out_o,
  output logic [PORT_W-1:0]   oe_o,
  output logic                irq_o
);
  localparam int unsigned SNS_W = 3 * PORT_W;

  logic [PORT_W-1:0] cnf_q, oe_q, out_q, sta_q, enb_q, pin_d_q;
  logic [SNS_W-1:0]  sns_q;
  logic [PORT_W-1:0] wsel, wval;
  logic [PORT_W-1:0] pol, edg, both, rise, fall, edge_hit, lvl_hit, set_v;
  logic [PORT_W-1:0] sta_base, sta_d;

  assign wval = wdata_i[0 +: PORT_W];
  assign wsel = wdata_i[PORT_W +: PORT_W];

  function automatic logic [PORT_W-1:0] upd(input logic [PORT_W-1:0] old,
                                            input logic msk,
                                            input logic [PORT_W-1:0] s,
                                            input logic [PORT_W-1:0] v);
    return msk ? ((old & ~s) | (v & s)) : v;
  endfunction

  // event detection on synchronized pins
  assign pol      = sns_q[0 +: PORT_W];
  assign edg      = sns_q[PORT_W +: PORT_W];
  assign both     = sns_q[2*PORT_W +: PORT_W];
  assign rise     = pin_i & ~pin_d_q;
  assign fall     = ~pin_i & pin_d_q;
  assign edge_hit = (both & (rise | fall)) | (~both & ((pol & rise) | (~pol & fall)));
  assign lvl_hit  = (pol & pin_i) | (~pol & ~pin_i);
  assign set_v    = (edg & edge_hit) | (~edg & lvl_hit);

  always_comb begin
    sta_base = sta_q;
    if (wr_i && sel_i == REG_STA) sta_base = upd(sta_q, masked_i, wsel, wval);
    if (wr_i && sel_i == REG_CLR && !masked_i) sta_base = sta_q & ~wval;
    sta_d = sta_base | set_v;  // event wins over clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnf_q   <= '0;
      oe_q    <= '0;
      out_q   <= '0;
      enb_q   <= '0;
      sns_q   <= '0;
      sta_q   <= '0;
      pin_d_q <= '0;
    end else begin
      sta_q   <= sta_d;
      pin_d_q <= pin_i;
      if (wr_i) begin
        unique case (sel_i)
          REG_CNF: cnf_q <= upd(cnf_q, masked_i, wsel, wval);
          REG_OE:  oe_q  <= upd(oe_q, masked_i, wsel, wval);
          REG_OUT: out_q <= upd(out_q, masked_i, wsel, wval);
          REG_ENB: enb_q <= upd(enb_q, masked_i, wsel, wval);
          REG_SNS: begin
            if (masked_i) sns_q[0 +: PORT_W] <= upd(pol, 1'b1, wsel, wval);
            else          sns_q <= wdata_i;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_o = '0;
    unique case (sel_i)
      REG_CNF: rd_o[PORT_W-1:0] = cnf_q;
      REG_OE:  rd_o[PORT_W-1:0] = oe_q;
      REG_OUT: rd_o[PORT_W-1:0] = out_q;
      REG_IN:  rd_o[PORT_W-1:0] = pin_i;
      REG_STA: rd_o[PORT_W-1:0] = sta_q;
      REG_ENB: rd_o[PORT_W-1:0] = enb_q;
      REG_SNS: rd_o[SNS_W-1:0]  = sns_q;
      REG_CLR: rd_o = '0;
      default: rd_o = '0;
    endcase
  end

  assign out_o = out_q;
  assign oe_o  = cnf_q & oe_q;
  assign irq_o = |(sta_q & enb_q);

  // R6
  sta_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_v != '0) |=> ((sta_q & $past(set_v)) == $past(set_v)));

  // R8
  sta_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !masked_i && sel_i == REG_CLR) |=> ((sta_q & $past(wval & ~set_v)) == '0));

  // R3
  mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && masked_i && sel_i == REG_OUT) |=> (((out_q ^ $past(out_q)) & ~$past(wsel)) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [11:0]                   addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic                          we_i,
  input  logic                          re_i,
  output logic [DATA_W-1:0]             rdata_o,
  input  logic [NUM_PORTS*PORT_W-1:0]   pins_i,
  output logic [NUM_PORTS*PORT_W-1:0]   pins_o,
  output logic [NUM_PORTS*PORT_W-1:0]   pins_oe_o,
  output logic                          irq_o
);
  localparam int unsigned NPINS = NUM_PORTS * PORT_W;
  localparam int unsigned SNS_W = 3 * PORT_W;

  logic [NPINS-1:0]  pins_sync;
  logic [DATA_W-1:0] port_rd [NUM_PORTS];
  logic [NUM_PORTS-1:0] port_irq;
  logic [DATA_W-1:0] rd_next, rdata_q;
  reg_sel_e          rsel;
  logic              alias_win, in_range, mapped;
  logic [1:0]        pidx;
  logic              unused_bits;

  assign rsel      = reg_sel_e'(addr_i[6:4]);
  assign alias_win = addr_i[ALIAS_BIT];
  assign pidx      = addr_i[3:2];
  assign in_range  = (addr_i[10:7] == 4'd0) && (int'(pidx) < int'(NUM_PORTS));
  assign mapped    = in_range && !(alias_win && (rsel == REG_IN || rsel == REG_CLR));
  assign unused_bits = ^{addr_i[1:0], wdata_i[DATA_W-1:SNS_W]};

  gpio_sync #(.WIDTH(NPINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (pins_sync)
  );

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    gpio_port #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (we_i && mapped && (int'(pidx) == g)),
      .masked_i(alias_win),
      .sel_i   (rsel),
      .wdata_i (wdata_i[SNS_W-1:0]),
      .pin_i   (pins_sync[g*PORT_W +: PORT_W]),
      .rd_o    (port_rd[g]),
      .out_o   (pins_o[g*PORT_W +: PORT_W]),
      .oe_o    (pins_oe_o[g*PORT_W +: PORT_W]),
      .irq_o   (port_irq[g])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int g = 0; g < int'(NUM_PORTS); g++) begin
      if (mapped && int'(pidx) == g) rd_next = port_rd[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= re_i ? rd_next : '0;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |port_irq;

  // R10
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> (rdata_o == '0));
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  typedef struct packed {
    logic [11:0] waddr;
    logic [31:0] wdata;
    logic [11:0] raddr;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{12'h000, 32'h0000_00A5, 12'h000, 32'h0000_00A5, 4'd2},  // R2 configure port0
    '{12'h00C, 32'h0000_003C, 12'h00C, 32'h0000_003C, 4'd2},  // R2 configure port3
    '{12'h100, 32'hFFFF_FFFF, 12'h800, 32'h0000_00A5, 4'd2},  // R2 unmapped write ignored, alias read
    '{12'h800, 32'h0000_0F0A, 12'h000, 32'h0000_00AA, 4'd3},  // R3 masked low nibble
    '{12'h820, 32'h0000_00FF, 12'h020, 32'h0000_0000, 4'd3},  // R3 no pins selected
    '{12'h064, 32'h0001_0203, 12'h064, 32'h0001_0203, 4'd2},  // R2 sense 24-bit write
    '{12'h864, 32'h0000_0300, 12'h064, 32'h0001_0200, 4'd3},  // R3 masked sense: polarity only
    '{12'h070, 32'h0000_00FF, 12'h070, 32'h0000_0000, 4'd8},  // R8 clear reads zero
    '{12'h030, 32'h0000_00FF, 12'h030, 32'h0000_0000, 4'd5}   // R5 input write ignored
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [31:0] rdata_o;
  logic [31:0] pins_i = '0;
  logic [31:0] pins_o, pins_oe_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_bank u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .we_i     (we_i),
    .re_i     (re_i),
    .rdata_o  (rdata_o),
    .pins_i   (pins_i),
    .pins_o   (pins_o),
    .pins_oe_o(pins_oe_o),
    .irq_o    (irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    addr_i = a; re_i = 1'b1;
    @(negedge clk_i);
    re_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", WD_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(1);

    // R1 reset state
    check("R1 pins_oe", pins_oe_o, 32'h0);
    check("R1 pins_o", pins_o, 32'h0);
    check("R1 irq", {31'h0, irq_o}, 32'h0);
    bus_read(12'h050, rd); check("R1 enable reg", rd, 32'h0);

    for (int i = 0; i < 9; i++) begin
      bus_write(VECS[i].waddr, VECS[i].wdata);
      bus_read(VECS[i].raddr, rd);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].exp);
    end

    // R4 output enable gating
    bus_write(12'h010, 32'hFF);
    check("R4 oe gated by cnf", pins_oe_o, 32'h0000_00AA);
    bus_write(12'h020, 32'h55);
    check("R4 pin value", pins_o, 32'h0000_0055);

    // R5 synchronized input
    pins_i = 32'h1234_5678;
    wait_cyc(3);
    bus_read(12'h030, rd); check("R5 port0 in", rd, 32'h78);
    bus_read(12'h034, rd); check("R5 port1 in", rd, 32'h56);
    bus_read(12'h03C, rd); check("R5 port3 in", rd, 32'h12);
    pins_i = '0;
    wait_cyc(4);

    // R10 unmapped read and idle zero
    bus_read(12'h100, rd); check("R10 unmapped", rd, 32'h0);
    bus_read(12'h830, rd); check("R10 alias input", rd, 32'h0);
    bus_read(12'h000, rd);
    wait_cyc(1);
    check("R10 idle zero", rdata_o, 32'h0);

    // R7 default level-low sets status
    bus_read(12'h048, rd); check("R7 level-low default", rd, 32'hFF);
    // port2: pin0 rising edge, others falling edge
    bus_write(12'h068, 32'h00FF01);
    bus_write(12'h078, 32'hFF);
    bus_read(12'h048, rd); check("R8 clear all", rd, 32'h0);
    bus_write(12'h058, 32'h01);
    check("R9 irq low when status clear", {31'h0, irq_o}, 32'h0);

    // R11 latency
    pins_i[16] = 1'b1;
    wait_cyc(2);
    check("R11 not yet after two edges", {31'h0, irq_o}, 32'h0);
    wait_cyc(1);
    check("R11 set on third edge", {31'h0, irq_o}, 32'h1);
    bus_read(12'h048, rd); check("R6 rising", rd, 32'h01);
    bus_write(12'h078, 32'hFE);
    bus_read(12'h048, rd); check("R8 zero bit no effect", rd, 32'h01);
    bus_write(12'h078, 32'h01);
    bus_read(12'h048, rd); check("R8 clear bit", rd, 32'h0);
    check("R9 irq drops", {31'h0, irq_o}, 32'h0);
    pins_i[16] = 1'b0; wait_cyc(4);
    bus_read(12'h048, rd); check("R6 rising ignores fall", rd, 32'h0);

    // R6 falling via masked polarity write
    bus_write(12'h868, 32'h0100);
    bus_read(12'h068, rd); check("R3 masked sense", rd, 32'h00FF00);
    pins_i[16] = 1'b1; wait_cyc(4);
    bus_read(12'h048, rd); check("R6 falling ignores rise", rd, 32'h0);
    pins_i[16] = 1'b0; wait_cyc(4);
    bus_read(12'h048, rd); check("R6 falling", rd, 32'h01);
    bus_write(12'h078, 32'h01);

    // R6 both edges
    bus_write(12'h068, 32'h01FF00);
    pins_i[16] = 1'b1; wait_cyc(4);
    bus_read(12'h048, rd); check("R6 both rise", rd, 32'h01);
    bus_write(12'h078, 32'h01);
    pins_i[16] = 1'b0; wait_cyc(4);
    bus_read(12'h048, rd); check("R6 both fall", rd, 32'h01);
    bus_write(12'h078, 32'h01);

    // R7 level high
    bus_write(12'h068, 32'h00FE01);
    bus_write(12'h078, 32'hFF);
    bus_read(12'h048, rd); check("R7 level high idle", rd, 32'h0);
    pins_i[16] = 1'b1; wait_cyc(4);
    bus_read(12'h048, rd); check("R7 level high set", rd, 32'h01);
    bus_write(12'h078, 32'h01);
    bus_read(12'h048, rd); check("R7 clear defeated while active", rd, 32'h01);
    pins_i[16] = 1'b0; wait_cyc(4);
    bus_write(12'h078, 32'h01);
    bus_read(12'h048, rd); check("R7 clear after release", rd, 32'h0);

    // R12 event beats simultaneous clear
    bus_write(12'h068, 32'h00FF01);
    bus_write(12'h078, 32'hFF);
    pins_i[16] = 1'b1;
    wait_cyc(2);
    bus_write(12'h078, 32'h01);
    bus_read(12'h048, rd); check("R12 event wins", rd, 32'h01);
    check("R12 irq", {31'h0, irq_o}, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule